// File: doc/BRIEF.md
# Coprocessor Bus Interface

This block is the bus-facing half of a numeric coprocessor that shares a synchronous bus with a host CPU. A double-rate input clock is divided by two to form the internal clock phase. The reset input fixes the divider phase, so the divided clock stays aligned with the host's. On each internal clock edge the block samples the address strobe, the 24-bit address and the cycle-type lines. It claims only I/O cycles aimed at its reserved ports, and it answers each claimed cycle with a ready pulse in that cycle's second clock.

Opcodes arrive on one port and operand words pass through a second port. That second port also answers at an alias address. Operand words are held in a 4-entry, 16-bit FIFO. A stub execution unit models the arithmetic with a latency and an exception flag, both taken from the opcode word. While the unit works, the block drives three signals back to the host:

- busy holds off the next opcode;
- the operand request paces data transfers in either direction;
- the error output reports an exception until software clears it.

Top module: `cop_bus_if`

## Requirements
- R1: `clk_ph` is 0 while `rst_in` is high and toggles on every rising `clk2` edge afterwards. A `clk2` edge on which `clk_ph` was 1 is an internal clock edge, and the first one comes on the second `clk2` edge after reset is released.
- R2: A cycle is claimed only if, in the internal clock where `ads_n` is low, `m_io` is 0 and `addr` equals 0x8000F8, 0x8000FC or 0x8000FE (bit 23 set). Memory cycles, addresses with bit 23 clear and any other I/O address get no ready and change no state.
- R3: `bus_rdy` is high during the whole second internal clock of a claimed cycle, and low at every other time. The transfer completes at the edge that ends that clock.
- R4: Port 0x8000FE acts exactly like port 0x8000FC, for both reads and writes.
- R5: A write to port 0x8000F8 while idle is an opcode, except for the value 0x00E2. The opcode fields are: bits [2:0] operand count (5 to 7 act as 4), bit 3 direction (0 = host sends operands, 1 = coprocessor returns them), bits [7:4] latency L, bit 8 exception. `busy` is high from the clock after the opcode is accepted. For an opcode with no operands, `busy` stays high for exactly L+1 internal clocks.
- R6: For a host-to-coprocessor opcode, `opnd_req` is high while operands are still owed and the FIFO is not full. Data-port writes at any other time are dropped. An opcode with a count of 0 never raises `opnd_req`.
- R7: A coprocessor-to-host opcode with count n returns the words S, S+1, … S+n-1 in order, where S is the 16-bit wrapped sum of the operands of the latest host-to-coprocessor opcode. `opnd_req` is high only while a returned word waits in the FIFO, and `busy` falls after the last word is read.
- R8: When an opcode with the exception bit completes, `err` goes high. It stays high until 0x00E2 is written to port 0x8000F8 while `busy` is low. That write clears `err` and does not raise `busy`.
- R9: A write to port 0x8000F8 while `busy` is high is ignored, including the value 0x00E2. It sets `proto_err`, which stays high until reset.
- R10: Reset drives `bus_rdy`, `busy`, `opnd_req`, `err`, `proto_err` and `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate input clock |
| rst_in | input | 1 | Synchronous reset, active high; also aligns the clock divider |
| ads_n | input | 1 | Address strobe, active low |
| addr | input | 24 | Bus address |
| w_r | input | 1 | 1 = write cycle, 0 = read cycle |
| m_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wdata | input | 16 | Write data from the host |
| rdata | output | 16 | Read data to the host (FIFO head during a data-port read, else 0) |
| bus_rdy | output | 1 | Ready for a claimed cycle, second internal clock only |
| clk_ph | output | 1 | Internal clock phase (clk2 divided by two) |
| busy | output | 1 | Instruction in progress |
| opnd_req | output | 1 | Operand transfer requested |
| err | output | 1 | Exception pending |
| proto_err | output | 1 | Sticky flag: opcode written while busy |

## Verification
Decode is tried with a table of cycles that each differ from a claimed one in a single field: the memory/IO line, address bit 23, a neighbouring low address, a non-zero middle byte, and a write in place of a read. A missing term in the select logic therefore shows up as a spurious ready or a spurious busy. Directed sequences then compare an opcode with no operands against the busy length L+1. One load moves its operands through both data addresses, so a broken alias corrupts the returned sum. A four-word load fills the FIFO exactly, and the write that follows it checks that late operands are dropped. A store checks both the word order and the request pacing. Error clearing is tried while busy and while idle, so that the ignore rule and the clear rule are told apart.

// File: rtl/cop_bus_if.sv
module cop_bus_if #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int LATW = 4,
  parameter logic [AW-1:0] OP_PORT = 24'h8000F8,
  parameter logic [AW-1:0] DAT_PORT = 24'h8000FC,
  parameter logic [AW-1:0] ALIAS_PORT = 24'h8000FE,
  parameter logic [DW-1:0] CLR_OP = 16'h00E2
) (
  input  logic          clk2,
  input  logic          rst_in,
  input  logic          ads_n,
  input  logic [AW-1:0] addr,
  input  logic          w_r,
  input  logic          m_io,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bus_rdy,
  output logic          clk_ph,
  output logic          busy,
  output logic          opnd_req,
  output logic          err,
  output logic          proto_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_EXEC, S_STORE} st_t;
  st_t st;

  logic ph, tick;
  always_ff @(posedge clk2)
    if (rst_in) ph <= 1'b0;
    else        ph <= ~ph;
  assign clk_ph = ph;
  assign tick = ph;

  logic hit_op, hit_dat, sel;
  assign hit_op  = addr == OP_PORT;
  assign hit_dat = (addr == DAT_PORT) || (addr == ALIAS_PORT);
  assign sel     = !ads_n && !m_io && addr[AW-1] && (hit_op || hit_dat);

  logic cyc_op, cyc_wr;
  always_ff @(posedge clk2)
    if (rst_in) begin
      bus_rdy <= 1'b0;
      cyc_op  <= 1'b0;
      cyc_wr  <= 1'b0;
    end else if (tick) begin
      bus_rdy <= sel;
      if (sel) begin
        cyc_op <= hit_op;
        cyc_wr <= w_r;
      end
    end

  logic op_wr, dat_wr, dat_rd, op_take, clr;
  assign op_wr   = tick && bus_rdy && cyc_op && cyc_wr;
  assign dat_wr  = tick && bus_rdy && !cyc_op && cyc_wr;
  assign dat_rd  = tick && bus_rdy && !cyc_op && !cyc_wr;
  assign busy    = st != S_IDLE;
  assign op_take = op_wr && !busy && wdata != CLR_OP;
  assign clr     = op_wr && !busy && wdata == CLR_OP;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, need, rx, k, need_in;
  logic [DW-1:0] acc, pdata;
  logic [LATW-1:0] lat;
  logic is_st, exc_f, full, empty, h_push, u_push, h_pop, u_pop, push, pop;

  assign full   = cnt == CW'(DEPTH);
  assign empty  = cnt == '0;
  assign h_push = dat_wr && st == S_LOAD && rx != need && !full;
  assign u_push = tick && st == S_STORE && k != need && !full;
  assign h_pop  = dat_rd && st == S_STORE && !empty;
  assign u_pop  = tick && st == S_EXEC && !empty;
  assign push   = h_push || u_push;
  assign pop    = h_pop || u_pop;
  assign pdata  = h_push ? wdata : acc + DW'(k);

  always_comb begin
    need_in = CW'(wdata[2:0]);
    if (int'(wdata[2:0]) > DEPTH) need_in = CW'(DEPTH);
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk2)
    if (push) mem[wp] <= pdata;

  always_ff @(posedge clk2)
    if (rst_in) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end

  assign rdata = (bus_rdy && !cyc_op && !cyc_wr && st == S_STORE && !empty) ? mem[rp] : '0;

  always_ff @(posedge clk2)
    if (rst_in) begin
      st <= S_IDLE;
      need <= '0;
      rx <= '0;
      k <= '0;
      lat <= '0;
      is_st <= 1'b0;
      exc_f <= 1'b0;
      acc <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (op_take) begin
          need  <= need_in;
          is_st <= wdata[3];
          lat   <= wdata[4 +: LATW];
          exc_f <= wdata[8];
          rx    <= '0;
          k     <= '0;
          if (!wdata[3] && need_in != '0) begin
            st  <= S_LOAD;
            acc <= '0;
          end else begin
            st <= S_EXEC;
          end
        end
        S_LOAD: if (h_push) begin
          rx <= rx + 1'b1;
          if (rx + 1'b1 == need) st <= S_EXEC;
        end
        S_EXEC: begin
          if (lat != '0) lat <= lat - 1'b1;
          if (!empty) acc <= acc + mem[rp];
          if (lat == '0 && empty) st <= (is_st && need != '0) ? S_STORE : S_IDLE;
        end
        S_STORE: begin
          if (u_push) k <= k + 1'b1;
          if (k == need && empty) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign opnd_req = (st == S_LOAD && rx != need && !full) || (st == S_STORE && !empty);

  always_ff @(posedge clk2)
    if (rst_in) begin
      err <= 1'b0;
      proto_err <= 1'b0;
    end else if (tick) begin
      if (st == S_EXEC && lat == '0 && empty && exc_f) err <= 1'b1;
      else if (clr) err <= 1'b0;
      if (op_wr && busy) proto_err <= 1'b1;
    end

  a_r3_rdy_from_sel: assert property (@(posedge clk2) disable iff (rst_in)
    $rose(bus_rdy) |-> $past(sel && tick));
  a_r3_rdy_full_clock: assert property (@(posedge clk2) disable iff (rst_in)
    $rose(bus_rdy) |=> bus_rdy);
  a_r5_busy_on_take: assert property (@(posedge clk2) disable iff (rst_in)
    op_take |=> busy);
  a_r6_fifo_bound: assert property (@(posedge clk2) disable iff (rst_in)
    cnt <= CW'(DEPTH));
  a_r6_req_only_busy: assert property (@(posedge clk2) disable iff (rst_in)
    opnd_req |-> busy);
  a_r8_err_hold: assert property (@(posedge clk2) disable iff (rst_in)
    err && !clr |=> err);
  a_r9_proto_sticky: assert property (@(posedge clk2) disable iff (rst_in)
    proto_err |=> proto_err);
endmodule

// File: tb/cop_bus_if_tb_top.sv
`timescale 1ns/1ps
module cop_bus_if_tb_top;
  logic clk2 = 1'b0, rst_in = 1'b1, ads_n = 1'b1, w_r = 1'b0, m_io = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic bus_rdy, clk_ph, busy, opnd_req, err, proto_err;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk2 = ~clk2;

  cop_bus_if dut_i (.clk2(clk2), .rst_in(rst_in), .ads_n(ads_n), .addr(addr), .w_r(w_r),
    .m_io(m_io), .wdata(wdata), .rdata(rdata), .bus_rdy(bus_rdy), .clk_ph(clk_ph),
    .busy(busy), .opnd_req(opnd_req), .err(err), .proto_err(proto_err));

  // {addr, w_r, m_io, expected ready}
  localparam logic [26:0] VEC [0:9] = '{
    {24'h8000F8, 1'b0, 1'b0, 1'b1},
    {24'h8000FC, 1'b0, 1'b0, 1'b1},
    {24'h8000FE, 1'b0, 1'b0, 1'b1},
    {24'h8000FC, 1'b0, 1'b1, 1'b0},
    {24'h0000FC, 1'b0, 1'b0, 1'b0},
    {24'h8000F0, 1'b0, 1'b0, 1'b0},
    {24'h8000FA, 1'b0, 1'b0, 1'b0},
    {24'h8001FC, 1'b0, 1'b0, 1'b0},
    {24'h8000F8, 1'b1, 1'b1, 1'b0},
    {24'h0000F8, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk2);
    @(posedge clk2);
    #1;
  endtask

  task automatic bus(input logic [23:0] a, input logic wr, input logic mio, input logic [15:0] d,
                     output logic rdy, output logic [15:0] q);
    ads_n = 1'b0; addr = a; w_r = wr; m_io = mio; wdata = d;
    tick();
    ads_n = 1'b1;
    rdy = bus_rdy;
    q = rdata;
    tick();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin n++; tick(); end
  endtask

  task automatic wait_req();
    for (int g = 0; g < 50 && !opnd_req; g++) tick();
  endtask

  task automatic do_reset();
    rst_in = 1'b1;
    repeat (4) @(posedge clk2);
    #1;
    chk("R10 busy", busy, 0); chk("R10 req", opnd_req, 0); chk("R10 err", err, 0);
    chk("R10 proto", proto_err, 0); chk("R10 rdy", bus_rdy, 0); chk("R10 rdata", rdata, 0);
    chk("R1 phase in reset", clk_ph, 0);
    @(negedge clk2) rst_in = 1'b0;
    @(posedge clk2); #1; chk("R1 phase 1", clk_ph, 1);
    @(posedge clk2); #1; chk("R1 phase 2", clk_ph, 0);
    @(posedge clk2); #1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic r;
    logic [15:0] q;
    int n;
    do_reset();

    // R2 R3 decode table
    for (int i = 0; i < 10; i++) begin
      bus(VEC[i][26:3], VEC[i][2], VEC[i][1], 16'h0010, r, q);
      chk($sformatf("R2 R3 ready vec %0d", i), r, VEC[i][0]);
      chk($sformatf("R3 ready low after vec %0d", i), bus_rdy, 0);
      chk($sformatf("R2 no effect vec %0d", i), busy, 0);
    end

    // R5 zero-operand busy length L+1, R6 no request
    bus(24'h8000F8, 1, 0, 16'h0030, r, q);
    chk("R5 busy after accept", busy, 1);
    n = 0;
    begin
      logic any_req = 1'b0;
      while (busy && n < 200) begin any_req |= opnd_req; n++; tick(); end
      chk("R6 no request for zero operands", any_req, 0);
    end
    chk("R5 busy length L=3", n, 4);

    // R9 opcode while busy ignored
    bus(24'h8000F8, 1, 0, 16'h0050, r, q);
    bus(24'h8000F8, 1, 0, 16'h0010, r, q);
    chk("R9 proto_err set", proto_err, 1);
    wait_idle(n);
    chk("R9 busy length unchanged", n + 2, 6);

    // R6 R4 load of three operands through both data addresses
    bus(24'h8000F8, 1, 0, 16'h0003, r, q);
    chk("R6 request on load", opnd_req, 1);
    bus(24'h8000FC, 1, 1, 16'h7777, r, q);
    chk("R2 memory write no ready", r, 0);
    bus(24'h8000FC, 1, 0, 16'h1111, r, q);
    bus(24'h8000FE, 1, 0, 16'h2222, r, q);
    chk("R4 alias write ready", r, 1);
    chk("R6 request while owed", opnd_req, 1);
    bus(24'h8000FC, 1, 0, 16'h0333, r, q);
    chk("R6 request drops when done", opnd_req, 0);
    wait_idle(n);
    chk("R6 load completes", busy, 0);

    // R7 store of three words
    bus(24'h8000F8, 1, 0, 16'h001B, r, q);
    chk("R7 no request before data", opnd_req, 0);
    for (int i = 0; i < 3; i++) begin
      wait_req();
      chk($sformatf("R7 request word %0d", i), opnd_req, 1);
      bus((i == 1) ? 24'h8000FE : 24'h8000FC, 0, 0, 16'h0, r, q);
      chk($sformatf("R7 R4 word %0d", i), q, 16'h3666 + 16'(i));
    end
    wait_idle(n);
    chk("R7 busy falls after last word", busy, 0);
    chk("R7 request low at end", opnd_req, 0);

    // R6 full FIFO and late write dropped
    bus(24'h8000F8, 1, 0, 16'h0004, r, q);
    for (int i = 0; i < 4; i++) bus(24'h8000FC, 1, 0, 16'h0100 << i, r, q);
    chk("R6 request off when full", opnd_req, 0);
    bus(24'h8000FC, 1, 0, 16'h5000, r, q);
    wait_idle(n);
    bus(24'h8000F8, 1, 0, 16'h0009, r, q);
    wait_req();
    bus(24'h8000FC, 0, 0, 16'h0, r, q);
    chk("R6 late write dropped", q, 16'h0F00);
    wait_idle(n);

    // R8 error set and clear rules
    bus(24'h8000F8, 1, 0, 16'h0100, r, q);
    tick();
    chk("R8 err set", err, 1);
    chk("R8 busy done", busy, 0);
    bus(24'h8000F8, 1, 0, 16'h0030, r, q);
    bus(24'h8000F8, 1, 0, 16'h00E2, r, q);
    wait_idle(n);
    chk("R9 R8 clear while busy ignored", err, 1);
    bus(24'h8000F8, 1, 0, 16'h00E2, r, q);
    chk("R8 err cleared", err, 0);
    chk("R8 clear raises no busy", busy, 0);
    chk("R9 proto_err still set", proto_err, 1);

    do_reset();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule